// File: doc/BRIEF.md
# Return-Address Stack With Fill Watermark Interrupt

This block is a last-in, first-out store for a processor sequencer. The sequencer pushes a program-counter-width word on a call or interrupt and pops it on return. The word on top of the stack is always visible on a read port. The block counts how many entries are occupied and exposes that count together with full and empty flags.

When a control enable bit is set, the block raises a stack-level interrupt. It does so early, before the stack actually runs dry or overfills. The interrupt rises while occupancy is below a low watermark or above a high watermark. It is a level signal and follows the fill count and the enable bit from cycle to cycle. Two further sticky flags record real misuse: a push into a full stack and a pop from an empty one.

By default the block is a 33-entry return-address stack. Its low watermark is 3, its high watermark is 28, and it is enabled by bit 10 of the control word. The package also holds constants for an 8-entry loop-stack variant that uses bit 11 of the control word. A status stack of 16 entries can be built from the same parameters.

Top module: `hwstk_top`

## Requirements
- R1: After synchronous reset the fill count is 0, `empty` is 1, `full` is 0, both sticky flags are 0, and `top_data` is 0.
- R2: A push without a pop, when the stack is not full, raises the fill count by one, and on the next cycle `top_data` shows the pushed word.
- R3: A pop without a push, when the stack is not empty, lowers the fill count by one and exposes the previous entry, so words come back in reverse push order.
- R4: A push without a pop when the fill count equals DEPTH leaves the fill count and the stored words unchanged and sets `overflow`. Only reset clears `overflow`.
- R5: While the stack is empty, `top_data` reads 0. A pop without a push on an empty stack leaves the fill count at 0 and sets `underflow`. Only reset clears `underflow`.
- R6: A push and a pop in the same cycle on a non-empty stack overwrite the top word with the pushed word and leave the fill count unchanged.
- R7: A push and a pop in the same cycle on an empty stack store nothing, leave the fill count at 0 and set `underflow`.
- R8: `level_irq` is 1 whenever bit EN_BIT of `ctrl_word` (bit 10 by default) is 1 and the fill count is below LOW_MARK (3 by default).
- R9: `level_irq` is 1 whenever bit EN_BIT of `ctrl_word` is 1 and the fill count is above HIGH_MARK (28 by default).
- R10: `level_irq` is 0 while bit EN_BIT is 0, and it is 0 while the fill count lies from LOW_MARK to HIGH_MARK inclusive. The other bits of `ctrl_word` have no effect.
- R11: The fill count never exceeds DEPTH, and `full` is 1 exactly when the count equals DEPTH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| push | input | 1 | Push request |
| pop | input | 1 | Pop request |
| push_data | input | WIDTH | Word to store on a push |
| ctrl_word | input | 16 | Control word; bit EN_BIT enables the stack-level interrupt |
| top_data | output | WIDTH | Current top word, 0 when empty |
| fill | output | $clog2(DEPTH+1) | Number of occupied entries |
| empty | output | 1 | No entry occupied |
| full | output | 1 | All entries occupied |
| level_irq | output | 1 | Watermark interrupt (level) |
| overflow | output | 1 | Sticky: push attempted while full |
| underflow | output | 1 | Sticky: pop attempted while empty |

## Verification
The assertions assume that `push`, `pop` and `ctrl_word` are known values that stay stable around each rising edge. They also assume the control word is a plain level input and not a pulse. The stimulus changes every input only on the falling edge, so each request is a whole-cycle value. The bench also drives both requests together in full, empty and middle states. This way the overflow, underflow and overwrite paths are each reached from a known fill count.

// File: rtl/hwstk_pkg.sv
package hwstk_pkg;

    localparam int CTRL_W      = 16;

    localparam int PC_DEPTH    = 33;
    localparam int PC_LOW      = 3;
    localparam int PC_HIGH     = 28;
    localparam int PC_EN_BIT   = 10;

    localparam int LOOP_DEPTH  = 8;
    localparam int LOOP_LOW    = 1;
    localparam int LOOP_HIGH   = 6;
    localparam int LOOP_EN_BIT = 11;

    localparam int STAT_DEPTH  = 16;

    typedef enum logic [1:0] {
        STK_IDLE = 2'd0,
        STK_PUSH = 2'd1,
        STK_POP  = 2'd2,
        STK_SWAP = 2'd3
    } stk_op_e;

    typedef struct packed {
        logic wr_en;
        logic wr_top;
        logic inc;
        logic dec;
        logic ovf_hit;
        logic unf_hit;
    } stk_ctl_t;

    function automatic stk_op_e decode_op(input logic push, input logic pop);
        return stk_op_e'({pop, push});
    endfunction

    function automatic stk_ctl_t plan_op(input stk_op_e op, input logic is_full,
                                         input logic is_empty);
        stk_ctl_t c;
        c = '0;
        unique case (op)
            STK_PUSH: begin
                c.wr_en   = !is_full;
                c.inc     = !is_full;
                c.ovf_hit = is_full;
            end
            STK_POP: begin
                c.dec     = !is_empty;
                c.unf_hit = is_empty;
            end
            STK_SWAP: begin
                c.wr_en   = !is_empty;
                c.wr_top  = !is_empty;
                c.unf_hit = is_empty;
            end
            default: c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/hwstk_regs.sv
module hwstk_regs #(
    parameter int DEPTH = 33,
    parameter int WIDTH = 24,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] slot [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst)
                slot[i] <= '0;
            else if (we && (waddr == AW'(i)))
                slot[i] <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        for (int k = 0; k < DEPTH; k++)
            if (raddr == AW'(k))
                rdata = slot[k];
    end

endmodule

// File: rtl/hwstk_fill.sv
module hwstk_fill
    import hwstk_pkg::*;
#(
    parameter int DEPTH = 33,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    output logic [CW-1:0] fill,
    output logic          full,
    output logic          empty,
    output logic          overflow,
    output logic          underflow,
    output logic          wr_en,
    output logic          wr_top
);

    stk_op_e  op;
    stk_ctl_t ctl;

    assign full  = (fill == CW'(DEPTH));
    assign empty = (fill == '0);

    always_comb begin
        op  = decode_op(push, pop);
        ctl = plan_op(op, full, empty);
    end

    assign wr_en  = ctl.wr_en;
    assign wr_top = ctl.wr_top;

    always_ff @(posedge clk) begin
        if (rst) begin
            fill      <= '0;
            overflow  <= 1'b0;
            underflow <= 1'b0;
        end else begin
            if (ctl.inc)
                fill <= fill + CW'(1);
            else if (ctl.dec)
                fill <= fill - CW'(1);
            if (ctl.ovf_hit)
                overflow <= 1'b1;
            if (ctl.unf_hit)
                underflow <= 1'b1;
        end
    end

    assert_fill_bound_R11: assert property (@(posedge clk) disable iff (rst)
        fill <= CW'(DEPTH));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (fill == CW'(DEPTH)) && overflow);

    assert_ovf_sticky_R4: assert property (@(posedge clk) disable iff (rst)
        overflow |=> overflow);

    assert_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (empty && pop) |=> (fill == '0) && underflow);

    assert_unf_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        underflow |=> underflow);

endmodule

// File: rtl/hwstk_irq.sv
module hwstk_irq
    import hwstk_pkg::*;
#(
    parameter int DEPTH     = 33,
    parameter int LOW_MARK  = 3,
    parameter int HIGH_MARK = 28,
    parameter int EN_BIT    = 10,
    localparam int CW       = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CW-1:0]     fill,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic              level_irq
);

    logic below, above;

    assign below     = (fill < CW'(LOW_MARK));
    assign above     = (fill > CW'(HIGH_MARK));
    assign level_irq = ctrl_word[EN_BIT] && (below || above);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        !ctrl_word[EN_BIT] |-> !level_irq);

    assert_irq_mid_R10: assert property (@(posedge clk) disable iff (rst)
        ((fill >= CW'(LOW_MARK)) && (fill <= CW'(HIGH_MARK))) |-> !level_irq);

    assert_irq_edges_R8: assert property (@(posedge clk) disable iff (rst)
        (ctrl_word[EN_BIT] && (fill == '0)) |-> level_irq);

endmodule

// File: rtl/hwstk_top.sv
module hwstk_top
    import hwstk_pkg::*;
#(
    parameter int DEPTH     = PC_DEPTH,
    parameter int WIDTH     = 24,
    parameter int LOW_MARK  = PC_LOW,
    parameter int HIGH_MARK = PC_HIGH,
    parameter int EN_BIT    = PC_EN_BIT,
    localparam int CW       = $clog2(DEPTH + 1),
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              push,
    input  logic              pop,
    input  logic [WIDTH-1:0]  push_data,
    input  logic [CTRL_W-1:0] ctrl_word,
    output logic [WIDTH-1:0]  top_data,
    output logic [CW-1:0]     fill,
    output logic              empty,
    output logic              full,
    output logic              level_irq,
    output logic              overflow,
    output logic              underflow
);

    logic             wr_en, wr_top;
    logic [CW-1:0]    top_cnt;
    logic [AW-1:0]    top_idx, waddr;
    logic [WIDTH-1:0] rdata;

    hwstk_fill #(.DEPTH(DEPTH)) u_fill (
        .clk(clk), .rst(rst), .push(push), .pop(pop),
        .fill(fill), .full(full), .empty(empty),
        .overflow(overflow), .underflow(underflow),
        .wr_en(wr_en), .wr_top(wr_top)
    );

    assign top_cnt = empty ? '0 : (fill - CW'(1));
    assign top_idx = AW'(top_cnt);
    assign waddr   = wr_top ? top_idx : AW'(fill);

    hwstk_regs #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst(rst), .we(wr_en), .waddr(waddr),
        .wdata(push_data), .raddr(top_idx), .rdata(rdata)
    );

    assign top_data = empty ? '0 : rdata;

    hwstk_irq #(
        .DEPTH(DEPTH), .LOW_MARK(LOW_MARK), .HIGH_MARK(HIGH_MARK), .EN_BIT(EN_BIT)
    ) u_irq (
        .clk(clk), .rst(rst), .fill(fill), .ctrl_word(ctrl_word), .level_irq(level_irq)
    );

    assert_push_R2: assert property (@(posedge clk) disable iff (rst)
        (push && !pop && !full) |=>
            (fill == $past(fill) + CW'(1)) && (top_data == $past(push_data)));

    assert_swap_R6: assert property (@(posedge clk) disable iff (rst)
        (push && pop && !empty) |=>
            (fill == $past(fill)) && (top_data == $past(push_data)));

    assert_empty_zero_R5: assert property (@(posedge clk) disable iff (rst)
        empty |-> (top_data == '0));

    assert_full_flag_R11: assert property (@(posedge clk) disable iff (rst)
        full |-> !empty && (fill != '0));

endmodule

// File: tb/hwstk_top_test.sv
module hwstk_top_test;
    import hwstk_pkg::*;

    localparam int DEPTH = PC_DEPTH;
    localparam int W     = 24;
    localparam int CW    = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst;
    logic              push, pop;
    logic [W-1:0]      push_data;
    logic [CTRL_W-1:0] ctrl_word;
    logic [W-1:0]      top_data;
    logic [CW-1:0]     fill;
    logic              empty, full, level_irq, overflow, underflow;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    int  q[$];
    bit  m_ovf, m_unf;

    always #4 clk = ~clk;

    hwstk_top #(.DEPTH(DEPTH), .WIDTH(W)) uut (
        .clk(clk), .rst(rst), .push(push), .pop(pop), .push_data(push_data),
        .ctrl_word(ctrl_word), .top_data(top_data), .fill(fill), .empty(empty),
        .full(full), .level_irq(level_irq), .overflow(overflow), .underflow(underflow)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        int sz;
        int exp_top;
        bit exp_irq;
        sz      = q.size();
        exp_top = (sz > 0) ? q[sz-1] : 0;
        exp_irq = ctrl_word[PC_EN_BIT] && ((sz < PC_LOW) || (sz > PC_HIGH));
        chk(tag, "fill", int'(fill), sz);
        chk(tag, "top_data", int'(top_data), exp_top);
        chk(tag, "empty", int'(empty), int'(sz == 0));
        chk(tag, "full", int'(full), int'(sz == DEPTH));
        chk(tag, "level_irq", int'(level_irq), int'(exp_irq));
        chk(tag, "overflow", int'(overflow), int'(m_ovf));
        chk(tag, "underflow", int'(underflow), int'(m_unf));
    endtask

    task automatic step(input bit p, input bit o, input int d, input string tag);
        push = p; pop = o; push_data = W'(d);
        @(posedge clk);
        if (p && o) begin
            if (q.size() > 0) q[q.size()-1] = d;
            else m_unf = 1;
        end else if (p) begin
            if (q.size() < DEPTH) q.push_back(d);
            else m_ovf = 1;
        end else if (o) begin
            if (q.size() > 0) void'(q.pop_back());
            else m_unf = 1;
        end
        @(negedge clk);
        push = 0; pop = 0;
        compare(tag);
    endtask

    task automatic do_reset();
        rst = 1; push = 0; pop = 0; push_data = '0;
        @(posedge clk); @(posedge clk);
        q.delete(); m_ovf = 0; m_unf = 0;
        @(negedge clk);
        rst = 0;
        compare("R1");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog R1 actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        ctrl_word = '0;
        @(negedge clk);
        do_reset();
        step(0, 0, 0, "R10_disabled_at_zero");
        ctrl_word = 16'h0400;
        step(0, 0, 0, "R8_enabled_empty");
        step(0, 1, 0, "R5_pop_empty");
        step(1, 1, 77, "R7_swap_empty");
        do_reset();
        ctrl_word = 16'h0400;
        for (int i = 1; i <= DEPTH; i++) begin
            if (i < PC_LOW)       step(1, 0, i * 37 + 5, "R8_push_low");
            else if (i > PC_HIGH) step(1, 0, i * 37 + 5, "R9_push_high");
            else                  step(1, 0, i * 37 + 5, "R2_push_mid");
        end
        step(0, 0, 0, "R11_full_flag");
        step(1, 0, 9999, "R4_push_full");
        step(1, 0, 8888, "R4_push_full_again");
        step(1, 1, 4242, "R6_swap_full");
        ctrl_word = 16'hFBFF;
        step(0, 0, 0, "R10_other_bits");
        ctrl_word = 16'h0400;
        for (int i = 0; i < 10; i++) step(0, 1, 0, "R3_pop_order");
        step(1, 1, 1234, "R6_swap_mid");
        step(0, 0, 0, "R10_mid_range");
        ctrl_word = 16'hFFFF;
        while (q.size() > 0) begin
            if (q.size() % 5 == 0) step(1, 1, q.size() + 300, "R6_swap_drain");
            step(0, 1, 0, "R3_pop_drain");
        end
        step(0, 1, 0, "R5_pop_empty_again");
        ctrl_word = 16'h0000;
        step(1, 0, 55, "R10_low_disabled");
        do_reset();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule